// File: doc/BRIEF.md
# Base Address Window Validator

This block holds the decoded state of six base address windows and one expansion ROM window. Each window arrives as a register value, a power-of-two size and a space type (I/O or memory), and the two space enables of the command register decide which kinds may be live. On a remap pulse the block walks the windows in index order, one per clock. For each window it works out the aligned base and the end address, applies the validity rules, and stores the result. A window that fails any rule, or whose space is disabled, is stored as unmapped. An unmapped window reads back a base of all ones.

Between evaluations the stored mapping is frozen. A lookup port compares an address and its space qualifier against every mapped window at once and returns one hit bit per window. After each walk the block raises a one-cycle change flag if any window's stored base moved. The flag lets the surrounding logic know that the decode has changed. Size checking is continuous: any nonzero size that is not a power of two is flagged on its own error bit, and that window is never mapped.

The controller has three states. IDLE waits; a remap pulse seen in IDLE takes the transition IDLE->EVAL. EVAL evaluates the window named by its index counter and stays in EVAL until the last window (the ROM, index 6) is done, then takes EVAL->REPORT. REPORT lasts exactly one cycle and always takes REPORT->IDLE. A remap pulse seen in EVAL or REPORT starts nothing.

Top module: `bar_window_validator`

## Requirements
- R1: A window's mapped base is its register value ANDed with the inverse of (size - 1), and its end address is base + size - 1; `map_base` shows the mapped base.
- R2: An I/O window can be mapped only while `cmd_en[0]` is 1, and a memory window only while `cmd_en[1]` is 1.
- R3: Window 6 is the expansion ROM. It is always treated as memory, whatever its `win_io` bit says, and it is mapped only if bit 0 of its own register value is 1.
- R4: An I/O window is left unmapped if its base is zero, if its end is not greater than its base, or if its end is 0x10000 or higher.
- R5: A memory window is left unmapped if its base is zero, if its end is not greater than its base, or if its end is 0xFFFFFFFF.
- R6: A window whose size is zero is unused. It is never mapped and never hits.
- R7: `size_err[w]` is 1 whenever window w has a nonzero size that is not a power of two; such a window is left unmapped.
- R8: An unmapped window shows `map_valid[w]`=0 and `map_base` all ones. Every window is in this state after reset.
- R9: `hit[w]` is 1 only when window w is mapped, `lookup_io` equals the window's space (1 = I/O), and base <= `lookup_addr` <= end.
- R10: A remap pulse in IDLE starts a walk. Windows 0 to 6 are evaluated on the next seven clock edges, and one REPORT cycle follows. In that cycle `map_changed` is 1 exactly when some window's new base differs from its previously stored base. `map_changed` is 0 at every other time.
- R11: Outside a walk, `map_valid` and `map_base` keep their values no matter how the register, size, type or enable inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bar_vals | input | 224 | Register value of each window, 32 bits per window, window 0 in the low bits |
| win_sizes | input | 224 | Size of each window in bytes, 32 bits per window |
| win_io | input | 7 | Space type per window, 1 = I/O (ignored for window 6) |
| cmd_en | input | 2 | Bit 0: I/O space enable, bit 1: memory space enable |
| remap | input | 1 | Start a re-evaluation of all windows |
| lookup_addr | input | 32 | Address to match against the windows |
| lookup_io | input | 1 | Space of the lookup address, 1 = I/O |
| hit | output | 7 | Per-window match of the lookup address |
| map_valid | output | 7 | Per-window mapped flag |
| map_base | output | 224 | Stored mapped base per window, all ones when unmapped |
| size_err | output | 7 | Per-window non-power-of-two size flag |
| map_changed | output | 1 | One-cycle flag in REPORT when any base changed |

## Verification
The bound checker enforces several rules on every cycle. An unmapped window must carry an all-ones base and must never hit. A mapped window never holds a zero base. The change flag never lasts two cycles. The stored mapping never moves while the controller is in IDLE. Only the bench scenarios can show the decode arithmetic itself: the alignment mask, the I/O limit and all-ones end rules, the effect of the enable bits and the ROM enable bit, and inclusive matching at both window edges. The same holds for whether the change flag reflects a real base difference, which needs known prior and new configurations.

// File: rtl/bawv_pkg.sv
package bawv_pkg;
    // Controller states of the window walk
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVAL   = 2'd1,
        ST_REPORT = 2'd2
    } bawv_state_e;

    // Bit positions inside the space enable input
    localparam int EN_IO_BIT  = 0;
    localparam int EN_MEM_BIT = 1;
endpackage

// File: rtl/bawv_window_eval.sv
// Decodes one window: aligned base, end address and validity.
module bawv_window_eval #(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] IO_LIMIT = ADDR_W'(32'h0001_0000)
) (
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] size,
    input  logic              is_io,
    input  logic              is_rom,
    input  logic              io_en,
    input  logic              mem_en,
    output logic              ok,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] last
);
    logic [ADDR_W-1:0] size_m1;
    logic              bad_size;
    logic              shape_ok;

    always_comb begin
        size_m1  = size - 1'b1;
        base     = reg_val & ~size_m1;
        last     = base + size_m1;
        bad_size = (size == '0) || ((size & size_m1) != '0);
        shape_ok = (base != '0) && (last > base);
        if (bad_size) begin
            ok = 1'b0;
        end else if (is_io && !is_rom) begin
            ok = io_en && shape_ok && (last < IO_LIMIT);
        end else begin
            ok = mem_en && shape_ok && (last != '1) && (!is_rom || reg_val[0]);
        end
    end
endmodule

// File: rtl/bawv_hit_match.sv
// Parallel inclusive range match of the lookup address against stored windows.
module bawv_hit_match #(
    parameter int NUM_WIN = 7,
    parameter int ADDR_W  = 32
) (
    input  logic [NUM_WIN-1:0]        win_valid,
    input  logic [NUM_WIN-1:0]        win_io,
    input  logic [NUM_WIN*ADDR_W-1:0] win_base,
    input  logic [NUM_WIN*ADDR_W-1:0] win_last,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      addr_io,
    output logic [NUM_WIN-1:0]        hit
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        assign lo     = win_base[w*ADDR_W +: ADDR_W];
        assign hi     = win_last[w*ADDR_W +: ADDR_W];
        assign hit[w] = win_valid[w] && (win_io[w] == addr_io)
                        && (addr >= lo) && (addr <= hi);
    end
endmodule

// File: rtl/bar_window_validator.sv
module bar_window_validator #(
    parameter int NUM_BARS = 6,
    parameter int ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] IO_LIMIT = ADDR_W'(32'h0001_0000)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [(NUM_BARS+1)*ADDR_W-1:0]   bar_vals,
    input  logic [(NUM_BARS+1)*ADDR_W-1:0]   win_sizes,
    input  logic [NUM_BARS:0]                win_io,
    input  logic [1:0]                       cmd_en,
    input  logic                             remap,
    input  logic [ADDR_W-1:0]                lookup_addr,
    input  logic                             lookup_io,
    output logic [NUM_BARS:0]                hit,
    output logic [NUM_BARS:0]                map_valid,
    output logic [(NUM_BARS+1)*ADDR_W-1:0]   map_base,
    output logic [NUM_BARS:0]                size_err,
    output logic                             map_changed
);
    import bawv_pkg::*;

    localparam int NUM_WIN = NUM_BARS + 1;
    localparam int ROM_IDX = NUM_BARS;
    localparam int IDX_W   = $clog2(NUM_WIN);

    bawv_state_e       state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic              chg_acc;
    logic              last_idx;

    logic [ADDR_W-1:0] base_r [NUM_WIN];
    logic [ADDR_W-1:0] last_r [NUM_WIN];
    logic [NUM_WIN-1:0] vld_r;
    logic [NUM_WIN-1:0] io_r;

    // Selected window inputs
    logic [ADDR_W-1:0] sel_bar, sel_size;
    logic              sel_io, sel_rom;
    logic              ev_ok;
    logic [ADDR_W-1:0] ev_base, ev_last, ev_store;

    assign sel_bar  = bar_vals[int'(idx)*ADDR_W +: ADDR_W];
    assign sel_size = win_sizes[int'(idx)*ADDR_W +: ADDR_W];
    assign sel_rom  = (idx == IDX_W'(ROM_IDX));
    assign sel_io   = win_io[idx] && !sel_rom;
    assign last_idx = (idx == IDX_W'(NUM_WIN-1));
    assign ev_store = ev_ok ? ev_base : '1;

    bawv_window_eval #(.ADDR_W(ADDR_W), .IO_LIMIT(IO_LIMIT)) u_eval (
        .reg_val (sel_bar),
        .size    (sel_size),
        .is_io   (sel_io),
        .is_rom  (sel_rom),
        .io_en   (cmd_en[EN_IO_BIT]),
        .mem_en  (cmd_en[EN_MEM_BIT]),
        .ok      (ev_ok),
        .base    (ev_base),
        .last    (ev_last)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (remap)    state_nx = ST_EVAL;
            ST_EVAL:   if (last_idx) state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Window storage and walk counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            chg_acc <= 1'b0;
            vld_r   <= '0;
            io_r    <= '0;
            for (int w = 0; w < NUM_WIN; w++) begin
                base_r[w] <= '1;
                last_r[w] <= '0;
            end
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (remap) begin
                        idx     <= '0;
                        chg_acc <= 1'b0;
                    end
                end
                ST_EVAL: begin
                    vld_r[idx]  <= ev_ok;
                    io_r[idx]   <= sel_io;
                    base_r[idx] <= ev_store;
                    last_r[idx] <= ev_last;
                    if (ev_store != base_r[idx]) chg_acc <= 1'b1;
                    idx <= idx + 1'b1;
                end
                ST_REPORT: idx <= '0;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        map_changed = 1'b0;
        unique case (state)
            ST_REPORT: map_changed = chg_acc;
            default:   map_changed = 1'b0;
        endcase
    end

    logic [NUM_WIN*ADDR_W-1:0] last_flat;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_out
        logic [ADDR_W-1:0] sz;
        assign sz          = win_sizes[w*ADDR_W +: ADDR_W];
        assign size_err[w] = (sz != '0) && ((sz & (sz - 1'b1)) != '0);
        assign map_base[w*ADDR_W +: ADDR_W]  = base_r[w];
        assign last_flat[w*ADDR_W +: ADDR_W] = last_r[w];
    end

    assign map_valid = vld_r;

    bawv_hit_match #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_hit (
        .win_valid (vld_r),
        .win_io    (io_r),
        .win_base  (map_base),
        .win_last  (last_flat),
        .addr      (lookup_addr),
        .addr_io   (lookup_io),
        .hit       (hit)
    );
endmodule

// File: rtl/bawv_checker.sv
module bawv_checker #(
    parameter int NUM_WIN = 7,
    parameter int ADDR_W  = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input bawv_pkg::bawv_state_e       state,
    input logic [NUM_WIN-1:0]          hit,
    input logic [NUM_WIN-1:0]          map_valid,
    input logic [NUM_WIN*ADDR_W-1:0]   map_base,
    input logic                        map_changed
);
    import bawv_pkg::*;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        // R8: unmapped window carries an all-ones base
        p_unmapped_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !map_valid[w] |-> (map_base[w*ADDR_W +: ADDR_W] == '1));

        // R9: no hit on an unmapped window
        p_nohit_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !map_valid[w] |-> !hit[w]);

        // R4 and R5: a zero base is never mapped
        p_base_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            map_valid[w] |-> (map_base[w*ADDR_W +: ADDR_W] != '0));
    end

    // R10: change flag lasts one cycle
    p_change_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        map_changed |=> !map_changed);

    // R11: mapping frozen while idle
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> ($stable(map_base) && $stable(map_valid)));
endmodule

bind bar_window_validator bawv_checker #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_bawv_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .hit         (hit),
    .map_valid   (map_valid),
    .map_base    (map_base),
    .map_changed (map_changed)
);

// File: tb/test_bar_window_validator.sv
`timescale 1ns/1ps
module test_bar_window_validator;
    localparam int NW = 7;
    localparam int AW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NW*AW-1:0]  bar_vals = '0;
    logic [NW*AW-1:0]  win_sizes = '0;
    logic [NW-1:0]     win_io = '0;
    logic [1:0]        cmd_en = 2'b00;
    logic              remap = 1'b0;
    logic [AW-1:0]     lookup_addr = '0;
    logic              lookup_io = 1'b0;
    logic [NW-1:0]     hit, map_valid, size_err;
    logic [NW*AW-1:0]  map_base;
    logic              map_changed;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bar_window_validator i_bar_window_validator (
        .clk(clk), .rst_n(rst_n), .bar_vals(bar_vals), .win_sizes(win_sizes),
        .win_io(win_io), .cmd_en(cmd_en), .remap(remap),
        .lookup_addr(lookup_addr), .lookup_io(lookup_io), .hit(hit),
        .map_valid(map_valid), .map_base(map_base), .size_err(size_err),
        .map_changed(map_changed)
    );

    // {bar, size, is_io, cmd_en, exp_valid, exp_base} applied to window 0
    localparam logic [99:0] VEC [0:12] = '{
        {32'h8000_0000, 32'h0000_1000, 1'b0, 2'b10, 1'b1, 32'h8000_0000}, // R1 R2
        {32'h8000_0123, 32'h0000_1000, 1'b0, 2'b10, 1'b1, 32'h8000_0000}, // R1 mask
        {32'h8000_0000, 32'h0000_1000, 1'b0, 2'b01, 1'b0, 32'hFFFF_FFFF}, // R2 mem off
        {32'h0000_0000, 32'h0000_1000, 1'b0, 2'b10, 1'b0, 32'hFFFF_FFFF}, // R5 zero
        {32'hFFFF_F000, 32'h0000_1000, 1'b0, 2'b10, 1'b0, 32'hFFFF_FFFF}, // R5 end ones
        {32'h0000_0100, 32'h0000_0001, 1'b1, 2'b01, 1'b0, 32'hFFFF_FFFF}, // R4 end==base
        {32'h0000_1000, 32'h0000_0100, 1'b1, 2'b01, 1'b1, 32'h0000_1000}, // R4 ok
        {32'h0000_1000, 32'h0000_0100, 1'b1, 2'b10, 1'b0, 32'hFFFF_FFFF}, // R2 io off
        {32'h0000_FF00, 32'h0000_0100, 1'b1, 2'b01, 1'b1, 32'h0000_FF00}, // R4 top
        {32'h0001_0000, 32'h0000_0100, 1'b1, 2'b01, 1'b0, 32'hFFFF_FFFF}, // R4 limit
        {32'h0000_0000, 32'h0000_0100, 1'b1, 2'b01, 1'b0, 32'hFFFF_FFFF}, // R4 zero
        {32'h8000_0000, 32'h0000_0000, 1'b0, 2'b10, 1'b0, 32'hFFFF_FFFF}, // R6
        {32'h8000_0000, 32'h0000_0300, 1'b0, 2'b10, 1'b0, 32'hFFFF_FFFF}  // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Pulse remap, wait for the REPORT cycle, return the change flag seen there
    task automatic run_remap(output logic chg);
        @(negedge clk); remap = 1'b1;
        @(negedge clk); remap = 1'b0;
        repeat (7) @(negedge clk);
        chg = map_changed;
        @(negedge clk);
    endtask

    task automatic look(input logic [31:0] a, input logic io, input logic [6:0] exp, input string req);
        @(negedge clk);
        lookup_addr = a; lookup_io = io;
        #1;
        chk(req, 32'(hit), 32'(exp));
    endtask

    function automatic logic [31:0] wbase(input int w);
        return map_base[w*AW +: AW];
    endfunction

    initial begin
        logic        chg;
        logic [31:0] prev0;
        logic [31:0] sz;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 reset valid", 32'(map_valid), 32'h0);
        for (int w = 0; w < NW; w++) chk("R8 reset base", wbase(w), 32'hFFFF_FFFF);
        chk("R10 reset change", 32'(map_changed), 32'h0);
        chk("R9 reset hit", 32'(hit), 32'h0);

        prev0 = 32'hFFFF_FFFF;
        for (int i = 0; i < 13; i++) begin
            logic [99:0] v;
            v = VEC[i];
            @(negedge clk);
            bar_vals[31:0]  = v[99:68];
            win_sizes[31:0] = v[67:36];
            win_io[0]       = v[35];
            cmd_en          = v[34:33];
            #1;
            sz = v[67:36];
            chk("R7 size_err", 32'(size_err), {31'h0, (sz != 0) && ((sz & (sz - 1)) != 0)});
            run_remap(chg);
            chk("R1 R2 R4 R5 R6 valid", 32'(map_valid), {31'h0, v[32]});
            chk("R1 R8 base", wbase(0), v[31:0]);
            chk("R10 change flag", 32'(chg), {31'h0, v[31:0] != prev0});
            prev0 = v[31:0];
        end

        // Directed: hit windows
        @(negedge clk);
        win_sizes = '0; bar_vals = '0; win_io = '0;
        bar_vals[1*AW +: AW]  = 32'h4000_0000; win_sizes[1*AW +: AW] = 32'h100;
        bar_vals[2*AW +: AW]  = 32'h0000_2000; win_sizes[2*AW +: AW] = 32'h10; win_io[2] = 1'b1;
        bar_vals[6*AW +: AW]  = 32'h000C_0001; win_sizes[6*AW +: AW] = 32'h8000; win_io[6] = 1'b1;
        cmd_en = 2'b11;
        run_remap(chg);
        chk("R3 R2 valid set", 32'(map_valid), 32'h46);
        chk("R10 change on new", 32'(chg), 32'h1);
        chk("R3 rom base", wbase(6), 32'h000C_0000);
        look(32'h4000_0000, 1'b0, 7'b0000010, "R9 mem low edge");
        look(32'h4000_00FF, 1'b0, 7'b0000010, "R9 mem high edge");
        look(32'h4000_0100, 1'b0, 7'b0000000, "R9 mem past end");
        look(32'h3FFF_FFFF, 1'b0, 7'b0000000, "R9 mem below");
        look(32'h4000_0000, 1'b1, 7'b0000000, "R9 space mismatch");
        look(32'h0000_2000, 1'b1, 7'b0000100, "R9 io low");
        look(32'h0000_200F, 1'b1, 7'b0000100, "R9 io high");
        look(32'h0000_2010, 1'b1, 7'b0000000, "R9 io past");
        look(32'h0000_2000, 1'b0, 7'b0000000, "R9 io as mem");
        look(32'h000C_7FFF, 1'b0, 7'b1000000, "R3 rom as memory");
        look(32'h000C_0000, 1'b1, 7'b0000000, "R3 rom not io");
        look(32'h000C_8000, 1'b0, 7'b0000000, "R9 rom past");

        // R11: inputs move without remap
        @(negedge clk);
        bar_vals[1*AW +: AW] = 32'h5000_0000;
        cmd_en = 2'b00;
        repeat (4) @(negedge clk);
        chk("R11 base held", wbase(1), 32'h4000_0000);
        chk("R11 valid held", 32'(map_valid), 32'h46);
        look(32'h4000_0010, 1'b0, 7'b0000010, "R11 hit held");

        cmd_en = 2'b11;
        run_remap(chg);
        chk("R1 moved base", wbase(1), 32'h5000_0000);
        chk("R10 change on move", 32'(chg), 32'h1);
        run_remap(chg);
        chk("R10 no change", 32'(chg), 32'h0);

        // R3: ROM enable bit clear
        @(negedge clk);
        bar_vals[6*AW +: AW] = 32'h000C_0000;
        run_remap(chg);
        chk("R3 rom disabled", 32'(map_valid), 32'h06);
        chk("R3 rom base ones", wbase(6), 32'hFFFF_FFFF);
        chk("R10 change rom", 32'(chg), 32'h1);

        // R2: all enables off
        @(negedge clk);
        cmd_en = 2'b00;
        run_remap(chg);
        chk("R2 all off", 32'(map_valid), 32'h0);
        look(32'h5000_0000, 1'b0, 7'b0000000, "R9 off no hit");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule